// File: doc/BRIEF.md
# Two-Digit Seconds Counter (00 to 59)

This block keeps the seconds field of a time-of-day clock as two decimal digits. A one-cycle tick input advances the count by one. The units digit runs 0 to 9 and the tens digit runs 0 to 5, so the pair steps from 00 to 59 and then returns to 00. A registered pulse marks each rollover, so a minutes stage further down the chain can take it as its own tick.

Each digit is a chain of toggle flip-flops. A flip-flop's inverted output feeds back to its input, so each stage halves the rate of the stage before it. Stage weights are 1, 2, 4 and 8, from bit 0 to bit 3. A four-bit binary chain would run to fifteen. Each digit is therefore cut short by decoding its first illegal value on the increment path and clearing the digit on the same clock edge. The clear is synchronous, so an illegal value never shows on the outputs, not even for a moment. The tens digit detects six using only its two set bits, bit 2 and bit 1. The units digit compares against ten in full.

The tick, reset and rollover pins are plain control signals with no handshake. A tick is taken on every rising clock edge where it is high.

Top module: `sec_counter`

## Requirements
- R1: While rst_i is high at a rising edge, both digits become 0 and wrap_o becomes 0 on that edge.
- R2: At an edge with rst_i low and tick_i low, both digits keep their values and wrap_o is 0 afterwards.
- R3: At an edge with tick_i high and the units digit below 9, the units digit rises by one and the tens digit is unchanged.
- R4: At an edge with tick_i high, the units digit at 9 and the tens digit below 5, the units digit becomes 0 and the tens digit rises by one.
- R5: At an edge with tick_i high and the count at 59, both digits become 0. wrap_o is 1 for exactly the one following cycle, and it is 1 at no other time.
- R6: The tens output never shows a value above 5, and the units output never shows a value above 9, in any cycle.
- R7: Each digit is a plain 4-bit BCD value with weights 1, 2, 4 and 8 on bits 0 to 3. For example, seven ticks after reset, units_o reads 4'b0111.
- R8: When rst_i and tick_i are both high at the same edge, the reset wins and the count reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable; one step per edge while high |
| units_o | output | 4 | Units digit, BCD 0 to 9 |
| tens_o | output | 4 | Tens digit, BCD 0 to 5 |
| wrap_o | output | 1 | One-cycle pulse after 59 rolls to 00 |

## Verification
The bench targets the two truncation points: 9 rolling to 0 with a carry into the tens digit, and 59 rolling to 00. A wrong decode at these points would let the count run to a tenth units state or a sixth tens state. It would also show up as a missed or doubled tens increment, or as a wrap pulse that arrives late, lasts two cycles, or fires at 09. Runs of back-to-back ticks and long idle gaps catch a digit that drifts while enable is low. A reset raised together with a tick catches a design where the count beats the reset. A check after seven ticks confirms the bit weights of the BCD output.

// File: rtl/sec_counter_pkg.sv
package sec_counter_pkg;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned UNITS_MOD  = 10;
  localparam int unsigned TENS_MOD   = 6;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic {
    DECODE_FULL    = 1'b0,
    DECODE_SETBITS = 1'b1
  } decode_e;
endpackage

// File: rtl/toggle_stage.sv
module toggle_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic tog_i,
  output logic q_o
);
  logic q_r;
  logic d_w;

  // inverted output fed back to the data input when toggling
  always_comb begin
    if (clr_i)      d_w = 1'b0;
    else if (tog_i) d_w = ~q_r;
    else            d_w = q_r;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q_r <= 1'b0;
    else       q_r <= d_w;
  end

  assign q_o = q_r;
endmodule

// File: rtl/mod_digit.sv
module mod_digit
  import sec_counter_pkg::*;
#(
  parameter int unsigned W       = DIGIT_W,
  parameter int unsigned MODULUS = UNITS_MOD,
  parameter decode_e     DECODE  = DECODE_FULL
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ILLEGAL = W'(MODULUS);

  logic [W-1:0] cur;
  logic [W-1:0] nxt;
  logic [W-1:0] tog;
  logic         hit;
  logic         clr;

  assign nxt = cur + W'(1);

  // first illegal value detected on the incremented value
  generate
    if (DECODE == DECODE_SETBITS) begin : g_setbits
      assign hit = ((nxt & ILLEGAL) == ILLEGAL);
    end else begin : g_full
      assign hit = (nxt == ILLEGAL);
    end
  endgenerate

  assign clr    = en_i & hit;
  assign wrap_o = clr;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_lsb
        assign tog[i] = en_i;
      end else begin : g_upper
        assign tog[i] = en_i & (&cur[i-1:0]);
      end
      toggle_stage u_stage (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (clr),
        .tog_i (tog[i]),
        .q_o   (cur[i])
      );
    end
  endgenerate

  assign q_o = cur;

  // R6: digit stays inside its legal range
  a_r6_digit_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cur < ILLEGAL);

  // R2: no enable, no movement
  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cur));

  // R3/R4: wrap pulse only from the last legal value
  a_r4_wrap_from_top: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (cur == '0));
endmodule

// File: rtl/sec_counter.sv
module sec_counter
  import sec_counter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  output logic [3:0] units_o,
  output logic [3:0] tens_o,
  output logic       wrap_o
);
  logic [DIGIT_W-1:0] units_w;
  logic [DIGIT_W-1:0] tens_w;
  logic               units_carry;
  logic               tens_carry;
  logic               wrap_r;

  mod_digit #(
    .W       (DIGIT_W),
    .MODULUS (UNITS_MOD),
    .DECODE  (DECODE_FULL)
  ) u_units (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (tick_i),
    .q_o    (units_w),
    .wrap_o (units_carry)
  );

  mod_digit #(
    .W       (DIGIT_W),
    .MODULUS (TENS_MOD),
    .DECODE  (DECODE_SETBITS)
  ) u_tens (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (units_carry),
    .q_o    (tens_w),
    .wrap_o (tens_carry)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) wrap_r <= 1'b0;
    else       wrap_r <= tens_carry;
  end

  assign units_o = units_w;
  assign tens_o  = tens_w;
  assign wrap_o  = wrap_r;

  // R1: reset clears everything
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (units_o == 4'd0 && tens_o == 4'd0 && !wrap_o));

  // R3: plain step of the units digit
  a_r3_units_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && units_o != 4'd9) |=>
      (units_o == $past(units_o) + 4'd1 && tens_o == $past(tens_o)));

  // R5: rollover pulse shows 00 and came from 59 with a tick
  a_r5_wrap_shows_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |-> (units_o == 4'd0 && tens_o == 4'd0));

  a_r5_wrap_single: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> !wrap_o);

  // R6: tens never presents six or above
  a_r6_tens_below_six: assert property (@(posedge clk_i) disable iff (rst_i)
    tens_o <= 4'd5);
endmodule

// File: tb/sec_counter_bench.sv
`timescale 1ns/1ps
module sec_counter_bench;
  logic       clk = 1'b0;
  logic       rst_i;
  logic       tick_i;
  logic [3:0] units_o;
  logic [3:0] tens_o;
  logic       wrap_o;

  int checks = 0;
  int errors = 0;
  int cnt    = 0;
  bit exp_wrap = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sec_counter u_sec_counter (
    .clk_i   (clk),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .units_o (units_o),
    .tens_o  (tens_o),
    .wrap_o  (wrap_o)
  );

  function automatic int exp_units(input int c);
    return c % 10;
  endfunction

  function automatic int exp_tens(input int c);
    return c / 10;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge: drive, let one edge pass, check at the next negedge
  task automatic step(input bit t, input bit r);
    string req;
    rst_i  = r;
    tick_i = t;
    if (r)                req = "R1";
    else if (!t)          req = "R2";
    else if (cnt == 59)   req = "R5";
    else if (cnt % 10 == 9) req = "R4";
    else                  req = "R3";
    if (r && t) req = "R8";
    @(posedge clk);
    if (r) begin
      cnt = 0; exp_wrap = 1'b0;
    end else if (t) begin
      exp_wrap = (cnt == 59);
      cnt = (cnt == 59) ? 0 : cnt + 1;
    end else begin
      exp_wrap = 1'b0;
    end
    @(negedge clk);
    check(req, int'(units_o), exp_units(cnt), "units");
    check(req, int'(tens_o),  exp_tens(cnt),  "tens");
    check(req, int'(wrap_o),  int'(exp_wrap), "wrap");
    check("R6", int'(tens_o <= 4'd5 && units_o <= 4'd9), 1, "range");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_i = 1'b1; tick_i = 1'b0;
    @(negedge clk);
    step(1'b0, 1'b1);                      // R1 reset state
    // R7: seven ticks from zero read 0111
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    check("R7", int'(units_o), 7, "units bits 0111");
    check("R7", int'(units_o[3]), 0, "bit3 weight");
    // R2: idle gap
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // R4/R5: run through two full rollovers back to back
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0);
    // R8: reset with tick at the same edge
    step(1'b1, 1'b1);
    check("R8", int'(units_o) + int'(tens_o), 0, "reset beats tick");
    // R5: reach 59, idle, then roll
    for (int i = 0; i < 59; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);                      // wrap must be gone
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      step(r < 60, r == 99);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule